// File: doc/BRIEF.md
# Rotating-Priority Interrupt Resolver

This block is the priority core of one eight-input interrupt controller in the classic programmable style. It keeps a request register, an in-service register, a mask register and a rotating priority pointer. Every cycle it scans the pending requests in the order that the pointer sets. It picks the first unmasked request that lies above everything currently in service, and presents a vector made of a programmable base and the winning pin number.

A trigger stage in front of the block produces per-pin set strobes and a per-pin live-level view. A decoder supplies mask writes and end-of-interrupt/priority commands as separate strobes and fields. The processor side answers the single interrupt line with an acknowledge strobe. Once raised, the line holds until it is acknowledged. On acknowledge the winning pin either enters service or, in auto-EOI mode, only moves the priority ring. A special fully nested option lets further requests through while the cascade pin (pin 2) is in service.

Top module: `irq_prio_core`

## Requirements
- R1: After reset, irq_o is 0, all request, in-service and mask bits are clear, the rotate flag is clear, and the pointer is 7, so pin 0 is highest priority and pin 7 lowest; vector_o shows {vec_base, 3'd7}.
- R2: With pointer p, pins are ranked starting at pin (p+1) mod 8 and wrapping. vector_o is {vec_base, pin} for the highest-ranked eligible pin, or {vec_base, 3'd7} (spurious) when no pin is eligible. vector_o follows the registered state in the same cycle.
- R3: mask_wr loads mask_val, where bit n masks pin n. A masked pending request is never eligible and stays pending.
- R4: A request is eligible only if it ranks strictly above the highest-ranked in-service pin.
- R5: With sfnm_en high, in-service bit 2 is ignored when computing the blocking level.
- R6: irq_o rises on the clock edge after an eligible request is seen and then holds until int_ack. The edge that takes int_ack drives irq_o low, and irq_o can rise again on the following edge.
- R7: int_ack with an eligible winner (aeoi_en low) sets that pin's in-service bit. The pin's request bit clears unless req_level for that pin is high.
- R8: With aeoi_en high, int_ack sets no in-service bit. If the stored rotate flag is 1, the pointer moves to the acknowledged pin.
- R9: A command with cmd_eoi=1 and cmd_sel=0 clears the highest-ranked in-service bit. A command with cmd_eoi=1 and cmd_sel=1 clears in-service bit cmd_pin.
- R10: Every command stores cmd_rot as the rotate flag. An EOI command with cmd_rot=1 also sets the pointer to the pin it cleared, so that pin becomes lowest priority.
- R11: A command with cmd_eoi=0, cmd_sel=1 and cmd_rot=1 loads the pointer from cmd_pin.
- R12: int_ack with no eligible request changes no request, in-service or pointer state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_set | input | 8 | Per-pin request set strobes from the trigger stage |
| req_level | input | 8 | Per-pin live input level, used when acknowledging |
| mask_wr | input | 1 | Mask register write strobe |
| mask_val | input | 8 | New mask value, bit n masks pin n |
| cmd_stb | input | 1 | Command strobe |
| cmd_eoi | input | 1 | Command is an end-of-interrupt |
| cmd_sel | input | 1 | Command uses cmd_pin (specific) |
| cmd_rot | input | 1 | Rotate flag carried by the command |
| cmd_pin | input | 3 | Pin operand of the command |
| aeoi_en | input | 1 | Auto end-of-interrupt mode |
| sfnm_en | input | 1 | Special fully nested mode |
| vec_base | input | 5 | Upper vector bits |
| int_ack | input | 1 | Interrupt acknowledge strobe |
| irq_o | output | 1 | Interrupt request to the processor |
| vector_o | output | 8 | Vector of the current winner or spurious pin 7 |

## Verification
The bench nests requests so that a newer, higher pin must break through an older in-service pin, while a lower one must stay blocked. A resolver that ignored in-service blocking would report the lower pin at once. Specific and non-specific EOIs are mixed so that clearing the wrong bit would either release a request that should stay blocked or keep one blocked that should be released. Rotation is checked by loading and moving the pointer and then pending a pin just past the new pointer, which a fixed-priority design would rank wrongly. Acknowledges are also given with the input level held high, with auto-EOI on, with nothing eligible and with special fully nested mode on, where a wrong design would drop the request, set an in-service bit, or keep the cascade pin blocking.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
    parameter int unsigned NPIN     = 8;
    parameter int unsigned VEC_W    = 8;
    parameter int unsigned CASC_PIN = 2;
    localparam int unsigned PW      = $clog2(NPIN);
    localparam int unsigned BASE_W  = VEC_W - PW;

    typedef struct packed {
        logic [NPIN-1:0] req;
        logic [NPIN-1:0] isr;
        logic [NPIN-1:0] msk;
        logic [PW-1:0]   ptr;
        logic            rot;
        logic            raised;
    } core_st_t;
endpackage

// File: rtl/irq_ring_pick.sv
module irq_ring_pick
    import irq_prio_pkg::*;
#(
    parameter int unsigned N   = NPIN,
    parameter int unsigned W   = PW
) (
    input  logic [N-1:0] vec,
    input  logic [W-1:0] ptr,
    output logic         hit,
    output logic [W-1:0] pin
);
    // first set bit when scanning from (ptr+1) upward with wrap
    always_comb begin
        hit = 1'b0;
        pin = '0;
        for (int i = N - 1; i >= 0; i--) begin
            int unsigned idx;
            idx = (int'(ptr) + 1 + i) % N;
            if (vec[idx]) begin
                hit = 1'b1;
                pin = W'(idx);
            end
        end
    end
endmodule

// File: rtl/irq_pin_decode.sv
module irq_pin_decode
    import irq_prio_pkg::*;
#(
    parameter int unsigned N = NPIN,
    parameter int unsigned W = PW
) (
    input  logic [W-1:0] pin,
    input  logic         en,
    output logic [N-1:0] oh
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        assign oh[g] = en && (pin == W'(g));
    end
endmodule

// File: rtl/irq_prio_core.sv
module irq_prio_core
    import irq_prio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPIN-1:0]   req_set,
    input  logic [NPIN-1:0]   req_level,
    input  logic              mask_wr,
    input  logic [NPIN-1:0]   mask_val,
    input  logic              cmd_stb,
    input  logic              cmd_eoi,
    input  logic              cmd_sel,
    input  logic              cmd_rot,
    input  logic [PW-1:0]     cmd_pin,
    input  logic              aeoi_en,
    input  logic              sfnm_en,
    input  logic [BASE_W-1:0] vec_base,
    input  logic              int_ack,
    output logic              irq_o,
    output logic [VEC_W-1:0]  vector_o
);
    localparam logic [PW-1:0] SPUR_PIN = PW'(NPIN - 1);

    core_st_t st_q, st_d;

    function automatic logic [PW-1:0] rank_of(input logic [PW-1:0] p,
                                              input logic [PW-1:0] ptr);
        return PW'((int'(p) + NPIN - int'(ptr) - 1) % NPIN);
    endfunction

    // blocking level: in-service set, cascade bit dropped in nested mode
    logic [NPIN-1:0] isr_blk;
    logic            blk_hit, cand_hit, top_hit;
    logic [PW-1:0]   blk_pin, cand_pin, top_pin;
    logic            elig;
    logic [PW-1:0]   win_pin;

    always_comb begin
        isr_blk = st_q.isr;
        if (sfnm_en) isr_blk[CASC_PIN] = 1'b0;
    end

    irq_ring_pick u_blk  (.vec(isr_blk),              .ptr(st_q.ptr), .hit(blk_hit),  .pin(blk_pin));
    irq_ring_pick u_cand (.vec(st_q.req & ~st_q.msk), .ptr(st_q.ptr), .hit(cand_hit), .pin(cand_pin));
    irq_ring_pick u_top  (.vec(st_q.isr),             .ptr(st_q.ptr), .hit(top_hit),  .pin(top_pin));

    assign elig    = cand_hit &&
                     (!blk_hit || (rank_of(cand_pin, st_q.ptr) < rank_of(blk_pin, st_q.ptr)));
    assign win_pin = elig ? cand_pin : SPUR_PIN;

    // EOI target and one-hot masks
    logic            eoi_go;
    logic [PW-1:0]   eoi_pin;
    logic [NPIN-1:0] win_oh, eoi_oh;

    assign eoi_pin = cmd_sel ? cmd_pin : top_pin;
    assign eoi_go  = cmd_stb && cmd_eoi && (cmd_sel || top_hit);

    irq_pin_decode u_win_dec (.pin(win_pin), .en(elig),   .oh(win_oh));
    irq_pin_decode u_eoi_dec (.pin(eoi_pin), .en(eoi_go), .oh(eoi_oh));

    always_comb begin
        st_d = st_q;
        // acknowledge of the current winner
        if (int_ack) begin
            st_d.raised = 1'b0;
            if (elig) begin
                if (!req_level[win_pin]) st_d.req = st_d.req & ~win_oh;
                if (aeoi_en) begin
                    if (st_q.rot) st_d.ptr = win_pin;
                end else begin
                    st_d.isr = st_d.isr | win_oh;
                end
            end
        end else if (elig) begin
            st_d.raised = 1'b1;
        end
        st_d.req = st_d.req | req_set;
        if (mask_wr) st_d.msk = mask_val;
        // end-of-interrupt and priority commands
        if (cmd_stb) begin
            st_d.rot = cmd_rot;
            if (cmd_eoi) begin
                st_d.isr = st_d.isr & ~eoi_oh;
                if (eoi_go && cmd_rot) st_d.ptr = eoi_pin;
            end else if (cmd_sel && cmd_rot) begin
                st_d.ptr = cmd_pin;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.ptr <= SPUR_PIN;
        end else begin
            st_q     <= st_d;
        end
    end

    assign irq_o    = st_q.raised;
    assign vector_o = {vec_base, win_pin};

    // ---------------- assertions ----------------
    assert_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !elig |-> (vector_o[PW-1:0] == SPUR_PIN));

    assert_mask_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
        elig |-> !st_q.msk[vector_o[PW-1:0]]);

    assert_raise_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o && !int_ack |=> irq_o);

    assert_raise_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o && !int_ack && !elig |=> !irq_o);

    assert_ack_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        int_ack |=> !irq_o);

    assert_ack_isr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        int_ack && elig && !aeoi_en && !cmd_stb |=> st_q.isr[$past(win_pin)]);

    assert_aeoi_noisr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        int_ack && aeoi_en && !cmd_stb |=> st_q.isr == $past(st_q.isr));

    assert_ack_none_R12: assert property (@(posedge clk) disable iff (!rst_n)
        int_ack && !elig && !cmd_stb && !mask_wr && (req_set == '0)
        |=> $stable(st_q.req) && $stable(st_q.isr) && $stable(st_q.ptr));
endmodule

// File: tb/irq_prio_core_test.sv
module irq_prio_core_test;
    import irq_prio_pkg::*;
    localparam int CLK_PERIOD = 10;
    localparam logic [4:0] BASE = 5'b01000;

    logic clk = 1'b0;
    logic rst_n;
    logic [7:0] req_set, req_level, mask_val;
    logic mask_wr, cmd_stb, cmd_eoi, cmd_sel, cmd_rot, aeoi_en, sfnm_en, int_ack;
    logic [2:0] cmd_pin;
    logic [4:0] vec_base;
    logic irq_o;
    logic [7:0] vector_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_prio_core uut (
        .clk(clk), .rst_n(rst_n), .req_set(req_set), .req_level(req_level),
        .mask_wr(mask_wr), .mask_val(mask_val), .cmd_stb(cmd_stb),
        .cmd_eoi(cmd_eoi), .cmd_sel(cmd_sel), .cmd_rot(cmd_rot),
        .cmd_pin(cmd_pin), .aeoi_en(aeoi_en), .sfnm_en(sfnm_en),
        .vec_base(vec_base), .int_ack(int_ack), .irq_o(irq_o),
        .vector_o(vector_o)
    );

    typedef struct {
        logic       irq;
        logic [7:0] vec;
        string      tag;
    } exp_t;

    exp_t sb[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    // monitor: compares queued expectations away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (irq_o !== e.irq || vector_o !== e.vec) begin
                    errors++;
                    $display("FAIL %s: irq=%0b vec=%02h expected irq=%0b vec=%02h",
                             e.tag, irq_o, vector_o, e.irq, e.vec);
                end
            end
        end
    end

    task automatic chk(input logic irq, input logic [2:0] pin, input string tag);
        exp_t e;
        e.irq = irq; e.vec = {BASE, pin}; e.tag = tag;
        sb.push_back(e);
        wait (sb.size() == 0);
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic pulse_req(input logic [7:0] m);
        req_set = m; tick(); req_set = '0;
    endtask

    task automatic wr_mask(input logic [7:0] m);
        mask_val = m; mask_wr = 1'b1; tick(); mask_wr = 1'b0;
    endtask

    task automatic cmd(input logic e, input logic s, input logic r, input logic [2:0] p);
        cmd_eoi = e; cmd_sel = s; cmd_rot = r; cmd_pin = p; cmd_stb = 1'b1;
        tick(); cmd_stb = 1'b0;
    endtask

    task automatic ack();
        int_ack = 1'b1; tick(); int_ack = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; req_set = '0; req_level = '0; mask_wr = 1'b0; mask_val = '0;
        cmd_stb = 1'b0; cmd_eoi = 1'b0; cmd_sel = 1'b0; cmd_rot = 1'b0; cmd_pin = '0;
        aeoi_en = 1'b0; sfnm_en = 1'b0; int_ack = 1'b0; vec_base = BASE;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // basic selection, masking, blocking
        do_reset();
        chk(0, 3'd7, "R1 reset state");
        pulse_req(8'h28);
        chk(0, 3'd3, "R2 pin3 beats pin5");
        tick();
        chk(1, 3'd3, "R6 irq raised");
        wr_mask(8'h08);
        chk(1, 3'd5, "R3 pin3 masked");
        wr_mask(8'h00);
        chk(1, 3'd3, "R3 unmask keeps request");
        ack();
        chk(0, 3'd7, "R7 R4 pin5 blocked by isr3");
        tick();
        chk(0, 3'd7, "R4 no raise while blocked");
        ack();
        chk(0, 3'd7, "R12 ack with nothing eligible");
        pulse_req(8'h02);
        chk(0, 3'd1, "R4 pin1 above isr3");
        tick();
        chk(1, 3'd1, "R6 raise pin1");
        ack();
        chk(0, 3'd7, "R7 isr1 and isr3");
        cmd(1, 0, 0, 3'd0);
        chk(0, 3'd7, "R9 nonspecific clears isr1");
        cmd(1, 0, 0, 3'd0);
        chk(0, 3'd5, "R9 R12 isr3 cleared, pin5 kept");
        tick();
        chk(1, 3'd5, "R6 raise pin5");
        ack();
        pulse_req(8'h02);
        tick();
        ack();
        pulse_req(8'h08);
        chk(0, 3'd7, "R4 pin3 blocked by isr1");
        cmd(1, 1, 0, 3'd5);
        chk(0, 3'd7, "R9 specific clears isr5 only");
        cmd(1, 0, 0, 3'd0);
        chk(0, 3'd3, "R9 nonspecific clears isr1");

        // level held at acknowledge
        do_reset();
        req_level = 8'h04;
        pulse_req(8'h04);
        tick();
        chk(1, 3'd2, "R6 raise pin2");
        ack();
        chk(0, 3'd7, "R7 pin2 in service");
        cmd(1, 0, 0, 3'd0);
        chk(0, 3'd2, "R7 request kept while level high");
        req_level = 8'h00;
        ack();
        cmd(1, 0, 0, 3'd0);
        chk(0, 3'd7, "R7 request cleared with level low");

        // special fully nested
        do_reset();
        sfnm_en = 1'b1;
        pulse_req(8'h04);
        tick();
        ack();
        pulse_req(8'h10);
        chk(0, 3'd4, "R5 isr2 ignored");
        sfnm_en = 1'b0;
        chk(0, 3'd7, "R5 R4 isr2 blocks without nested mode");

        // rotation
        do_reset();
        cmd(0, 1, 1, 3'd4);
        pulse_req(8'h48);
        chk(0, 3'd6, "R11 pointer 4 puts pin6 over pin3");
        tick();
        ack();
        chk(0, 3'd7, "R2 pin3 ranks below isr6");
        cmd(1, 0, 1, 3'd0);
        chk(0, 3'd3, "R10 rotate on EOI releases pin3");
        pulse_req(8'h21);
        chk(1, 3'd0, "R10 pointer 6 puts pin0 first");

        // auto end of interrupt
        do_reset();
        aeoi_en = 1'b1;
        cmd(0, 0, 1, 3'd0);
        pulse_req(8'h24);
        chk(0, 3'd2, "R8 pin2 first");
        tick();
        ack();
        chk(0, 3'd5, "R8 no isr set, pin5 eligible");
        pulse_req(8'h02);
        chk(1, 3'd5, "R8 R10 pointer moved to pin2");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule